// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the register bookkeeping a small 32-bit processor performs when it enters an exception. A request names one of four causes: a software break, a non-maskable interrupt, a bus fault from address translation, or an external interrupt. The block captures the request together with the current program counter, delay-slot length, status word, stack pointers and exception base. It then writes the return registers, the status word, the stack pointers and the exception status word in one update cycle. Next it fetches the handler address from a vector table through a simple read port and loads that address into the program counter.

A version input selects between two entry flavours. On a current core (version 32 or above), the status word is shifted so that mode bits are stacked and the user flag is cleared. On that core the return address is also rewound over an active delay slot, and the exception status word carries the vector index. On an older core (version below 32), all three of those steps are skipped, and a bus fault cannot be handled: it is reported on an error output instead of being entered. After accepting a request, the block stays busy until the program counter load completes. A second bus fault that arrives while a bus fault is being entered is flagged as recursive.

Top module: `exc_entry_seq`

## Requirements
- R1: A break request (kind code 0) uses `trap_vec` as the vector and writes `erp_val` = return address with `erp_we`; `nrp_we` stays low.
- R2: A non-maskable request (kind code 1) uses vector 0, writes the return address to `nrp_val` with `nrp_we` (`erp_we` low), and clears status bit `M_BIT` (default 9) before any shift.
- R3: A bus-fault request (kind code 2) uses `fault_vec`, and an external interrupt (kind code 3) uses `irq_vec`; both write the return address through `erp_we`.
- R4: On a current core, `exs_we` pulses in the update cycle with `exs_val` = vector[7:0] at bits 15:8 and all other bits zero.
- R5: On a current core with a nonzero `dslot_len`, the saved return address is `pc_in - dslot_len`, and `dslot_clr` pulses in the update cycle.
- R6: When status bit `U_BIT` (default 8) is set on entry, `usp_we` writes the old `sp_in` and `sp_we` writes `ksp_in`; otherwise neither pulses.
- R7: On a current core, the new status word keeps old bits 31:30, places old bits 19:0 at 29:10, and zeroes bits 9:0, which clears the user flag.
- R8: The read request carries the address `ebp_in + vector*4` and holds until `mem_rd_valid`. In the next cycle, `pc_we` and `done` pulse together with `pc_val` equal to the data read.
- R9: When `core_ver` < 32, the status word is written unchanged except for the non-maskable M clear, `exs_we` stays low, `dslot_clr` stays low, and the return address is `pc_in` unrewound.
- R10: On an older core, a bus-fault request starts no entry; instead `fatal_bus_err` pulses for one cycle, the cycle after the request.
- R11: An accepted request drives the update outputs for exactly the next cycle, then the read. `busy` is high from the update cycle through the done cycle, and requests seen while busy are ignored.
- R12: A bus-fault request seen while a bus-fault entry is busy pulses `recursive_fault` in the following cycle and does not start a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_kind | input | 2 | 0 break, 1 non-maskable, 2 bus fault, 3 external interrupt |
| trap_vec | input | VEC_W | Break vector number |
| fault_vec | input | VEC_W | Bus-fault vector number |
| irq_vec | input | VEC_W | External interrupt vector number |
| pc_in | input | XLEN | Current program counter |
| dslot_len | input | DSL_W | Active delay-slot length, 0 when none |
| core_ver | input | VER_W | Core version number |
| ccs_in | input | XLEN | Current status word |
| sp_in | input | XLEN | Current stack pointer |
| ksp_in | input | XLEN | Kernel stack pointer |
| ebp_in | input | XLEN | Exception vector table base |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | XLEN | Read data |
| busy | output | 1 | Entry in progress |
| erp_we | output | 1 | Exception return register write |
| erp_val | output | XLEN | Exception return value |
| nrp_we | output | 1 | Non-maskable return register write |
| nrp_val | output | XLEN | Non-maskable return value |
| ccs_we | output | 1 | Status word write |
| ccs_val | output | XLEN | New status word |
| exs_we | output | 1 | Exception status word write |
| exs_val | output | XLEN | New exception status word |
| usp_we | output | 1 | User stack pointer write |
| usp_val | output | XLEN | Saved user stack pointer |
| sp_we | output | 1 | Stack pointer write |
| sp_val | output | XLEN | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot state |
| mem_rd_req | output | 1 | Handler address read request |
| mem_rd_addr | output | XLEN | Handler address location |
| pc_we | output | 1 | Program counter load |
| pc_val | output | XLEN | Handler address |
| done | output | 1 | Entry complete pulse |
| fatal_bus_err | output | 1 | Unhandled bus fault on an older core |
| recursive_fault | output | 1 | Bus fault during a bus-fault entry |

## Verification
A bad captured kind or a bad version decode shows up in the update cycle, one cycle after acceptance. It appears as the wrong return register strobe, a missing exception status write or a misplaced status bit. A corrupted vector shows up in the same cycle in `exs_val` and persists through the read address. Sequencing faults, such as a stuck or skipped state, show as `busy`, `mem_rd_req` or `done` differing from the reference on the very next edge, so each fault is reported within one or two cycles of its cause.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      EK_BREAK  = 2'd0,
      EK_NMI    = 2'd1,
      EK_BUSFLT = 2'd2,
      EK_IRQ    = 2'd3
   } exc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_UPDATE = 2'd1,
      ST_FETCH  = 2'd2,
      ST_DONE   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/exc_vec_select.sv
module exc_vec_select
   import exc_entry_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic [1:0]       kind,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic [VEC_W-1:0] fault_vec,
   input  logic [VEC_W-1:0] irq_vec,
   output logic [VEC_W-1:0] vec,
   output logic             to_nmi_ret
);

   initial begin
      if (VEC_W < 8) $error("exc_vec_select: VEC_W must be at least 8");
   end

   always_comb begin
      vec        = '0;
      to_nmi_ret = 1'b0;
      case (exc_kind_e'(kind))
         EK_BREAK:  vec = trap_vec;
         EK_NMI: begin
            vec        = '0;
            to_nmi_ret = 1'b1;
         end
         EK_BUSFLT: vec = fault_vec;
         default:   vec = irq_vec;
      endcase
   end

endmodule

// File: rtl/exc_status_xform.sv
module exc_status_xform #(
   parameter int XLEN  = 32,
   parameter int M_BIT = 9
) (
   input  logic [XLEN-1:0] ccs_old,
   input  logic            is_nmi,
   input  logic            legacy,
   output logic [XLEN-1:0] ccs_new
);

   localparam int KEEP_HI = 2;
   localparam int CLR_LO  = 10;
   localparam int MOVE_W  = XLEN - KEEP_HI - CLR_LO;

   logic [XLEN-1:0] masked;

   initial begin
      if (XLEN != 32) $error("exc_status_xform: XLEN must be 32");
      if (M_BIT >= XLEN) $error("exc_status_xform: M_BIT out of range");
   end

   always_comb begin
      masked = ccs_old;
      if (is_nmi) masked[M_BIT] = 1'b0;
   end

   always_comb begin
      if (legacy) begin
         ccs_new = masked;
      end else begin
         ccs_new = {masked[XLEN-1 -: KEEP_HI], masked[MOVE_W-1:0], {CLR_LO{1'b0}}};
      end
   end

endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc #(
   parameter int XLEN  = 32,
   parameter int DSL_W = 2
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [DSL_W-1:0] dsl,
   input  logic             legacy,
   output logic [XLEN-1:0]  ret_addr,
   output logic             rewind
);

   initial begin
      if (DSL_W < 1 || DSL_W >= XLEN) $error("exc_ret_calc: bad DSL_W");
   end

   assign rewind   = !legacy && (dsl != '0);
   assign ret_addr = rewind ? (pc - XLEN'(dsl)) : pc;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int VEC_W         = 8,
   parameter int DSL_W         = 2,
   parameter int VER_W         = 8,
   parameter int U_BIT         = 8,
   parameter int M_BIT         = 9,
   parameter int LEGACY_LIMIT  = 32,
   parameter bit LEGACY_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic [VEC_W-1:0] fault_vec,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic [XLEN-1:0]  pc_in,
   input  logic [DSL_W-1:0] dslot_len,
   input  logic [VER_W-1:0] core_ver,
   input  logic [XLEN-1:0]  ccs_in,
   input  logic [XLEN-1:0]  sp_in,
   input  logic [XLEN-1:0]  ksp_in,
   input  logic [XLEN-1:0]  ebp_in,
   input  logic             mem_rd_valid,
   input  logic [XLEN-1:0]  mem_rd_data,
   output logic             busy,
   output logic             erp_we,
   output logic [XLEN-1:0]  erp_val,
   output logic             nrp_we,
   output logic [XLEN-1:0]  nrp_val,
   output logic             ccs_we,
   output logic [XLEN-1:0]  ccs_val,
   output logic             exs_we,
   output logic [XLEN-1:0]  exs_val,
   output logic             usp_we,
   output logic [XLEN-1:0]  usp_val,
   output logic             sp_we,
   output logic [XLEN-1:0]  sp_val,
   output logic             dslot_clr,
   output logic             mem_rd_req,
   output logic [XLEN-1:0]  mem_rd_addr,
   output logic             pc_we,
   output logic [XLEN-1:0]  pc_val,
   output logic             done,
   output logic             fatal_bus_err,
   output logic             recursive_fault
);

   localparam int IDX_LO  = 8;
   localparam int IDX_W   = 8;
   localparam int VSHIFT  = 2;

   initial begin
      if (XLEN != 32) $error("exc_entry_seq: XLEN must be 32");
      if (VEC_W < IDX_W || VEC_W + VSHIFT > XLEN) $error("exc_entry_seq: bad VEC_W");
      if (U_BIT >= 10) $error("exc_entry_seq: U_BIT must fall in the cleared low field");
      if (M_BIT >= 10) $error("exc_entry_seq: M_BIT must fall in the cleared low field");
      if (VER_W < 1) $error("exc_entry_seq: bad VER_W");
   end

   // ---------------- version decode (variant chosen by parameter)
   logic legacy_now;
   generate
      if (LEGACY_EN) begin : g_legacy
         assign legacy_now = (core_ver < VER_W'(LEGACY_LIMIT));
      end else begin : g_modern_only
         assign legacy_now = 1'b0;
      end
   endgenerate

   // ---------------- captured request
   seq_state_e        state_q;
   logic [1:0]        kind_q;
   logic [VEC_W-1:0]  tvec_q, fvec_q, ivec_q;
   logic [XLEN-1:0]   pc_q, ccs_q, sp_q, ksp_q, ebp_q, rdata_q;
   logic [DSL_W-1:0]  dsl_q;
   logic              legacy_q;
   logic              fatal_q, rec_q;

   logic accept, legacy_bf;
   assign legacy_bf = req_valid && (exc_kind_e'(req_kind) == EK_BUSFLT) && legacy_now;
   assign accept    = (state_q == ST_IDLE) && req_valid && !legacy_bf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= '0;
         tvec_q   <= '0;
         fvec_q   <= '0;
         ivec_q   <= '0;
         pc_q     <= '0;
         ccs_q    <= '0;
         sp_q     <= '0;
         ksp_q    <= '0;
         ebp_q    <= '0;
         dsl_q    <= '0;
         legacy_q <= 1'b0;
         rdata_q  <= '0;
         fatal_q  <= 1'b0;
         rec_q    <= 1'b0;
      end else begin
         fatal_q <= (state_q == ST_IDLE) && legacy_bf;
         rec_q   <= (state_q != ST_IDLE) && req_valid
                    && (exc_kind_e'(req_kind) == EK_BUSFLT)
                    && (exc_kind_e'(kind_q) == EK_BUSFLT);
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q   <= req_kind;
                  tvec_q   <= trap_vec;
                  fvec_q   <= fault_vec;
                  ivec_q   <= irq_vec;
                  pc_q     <= pc_in;
                  ccs_q    <= ccs_in;
                  sp_q     <= sp_in;
                  ksp_q    <= ksp_in;
                  ebp_q    <= ebp_in;
                  dsl_q    <= dslot_len;
                  legacy_q <= legacy_now;
                  state_q  <= ST_UPDATE;
               end
            end
            ST_UPDATE: state_q <= ST_FETCH;
            ST_FETCH: begin
               if (mem_rd_valid) begin
                  rdata_q <= mem_rd_data;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- datapath pieces
   logic [VEC_W-1:0] vec_sel;
   logic             to_nmi;
   logic [XLEN-1:0]  ret_addr;
   logic             rewind;
   logic [XLEN-1:0]  ccs_next;

   exc_vec_select #(.VEC_W(VEC_W)) u_vsel (
      .kind       (kind_q),
      .trap_vec   (tvec_q),
      .fault_vec  (fvec_q),
      .irq_vec    (ivec_q),
      .vec        (vec_sel),
      .to_nmi_ret (to_nmi)
   );

   exc_ret_calc #(.XLEN(XLEN), .DSL_W(DSL_W)) u_ret (
      .pc       (pc_q),
      .dsl      (dsl_q),
      .legacy   (legacy_q),
      .ret_addr (ret_addr),
      .rewind   (rewind)
   );

   exc_status_xform #(.XLEN(XLEN), .M_BIT(M_BIT)) u_ccs (
      .ccs_old (ccs_q),
      .is_nmi  (to_nmi),
      .legacy  (legacy_q),
      .ccs_new (ccs_next)
   );

   // ---------------- outputs
   logic in_upd;
   logic user_mode;
   assign in_upd    = (state_q == ST_UPDATE);
   assign user_mode = ccs_q[U_BIT];

   assign busy      = (state_q != ST_IDLE);
   assign erp_we    = in_upd && !to_nmi;
   assign nrp_we    = in_upd && to_nmi;
   assign erp_val   = ret_addr;
   assign nrp_val   = ret_addr;
   assign ccs_we    = in_upd;
   assign ccs_val   = ccs_next;
   assign exs_we    = in_upd && !legacy_q;
   assign exs_val   = {{(XLEN-IDX_LO-IDX_W){1'b0}}, vec_sel[IDX_W-1:0], {IDX_LO{1'b0}}};
   assign usp_we    = in_upd && user_mode;
   assign usp_val   = sp_q;
   assign sp_we     = in_upd && user_mode;
   assign sp_val    = ksp_q;
   assign dslot_clr = in_upd && rewind;

   assign mem_rd_req  = (state_q == ST_FETCH);
   assign mem_rd_addr = ebp_q + {{(XLEN-VEC_W-VSHIFT){1'b0}}, vec_sel, {VSHIFT{1'b0}}};
   assign pc_we       = (state_q == ST_DONE);
   assign pc_val      = rdata_q;
   assign done        = (state_q == ST_DONE);
   assign fatal_bus_err   = fatal_q;
   assign recursive_fault = rec_q;

   // ---------------- assertions
   assert_one_ret_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erp_we, nrp_we}));

   assert_nmi_ret_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nrp_we |-> (exs_val[15:8] == 8'd0));

   assert_exs_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exs_we |-> (exs_val[7:0] == 8'd0 && exs_val[XLEN-1:16] == '0));

   assert_user_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ccs_we && exs_we) |-> (ccs_val[9:0] == 10'd0));

   assert_swap_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |-> usp_we);

   assert_pc_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_valid) |=> (pc_we && done));

   assert_read_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   assert_update_to_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ccs_we |=> (mem_rd_req && !ccs_we));

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_legacy_no_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_bus_err |-> !busy);

   assert_rec_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      recursive_fault |-> $past(busy));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_kind;
   logic [7:0]  trap_vec, fault_vec, irq_vec;
   logic [31:0] pc_in, ccs_in, sp_in, ksp_in, ebp_in;
   logic [1:0]  dslot_len;
   logic [7:0]  core_ver;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_data;

   logic        busy, erp_we, nrp_we, ccs_we, exs_we, usp_we, sp_we, dslot_clr;
   logic        mem_rd_req, pc_we, done, fatal_bus_err, recursive_fault;
   logic [31:0] erp_val, nrp_val, ccs_val, exs_val, usp_val, sp_val, mem_rd_addr, pc_val;

   exc_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
      .pc_in(pc_in), .dslot_len(dslot_len), .core_ver(core_ver),
      .ccs_in(ccs_in), .sp_in(sp_in), .ksp_in(ksp_in), .ebp_in(ebp_in),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .busy(busy), .erp_we(erp_we), .erp_val(erp_val), .nrp_we(nrp_we), .nrp_val(nrp_val),
      .ccs_we(ccs_we), .ccs_val(ccs_val), .exs_we(exs_we), .exs_val(exs_val),
      .usp_we(usp_we), .usp_val(usp_val), .sp_we(sp_we), .sp_val(sp_val),
      .dslot_clr(dslot_clr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .pc_we(pc_we), .pc_val(pc_val), .done(done),
      .fatal_bus_err(fatal_bus_err), .recursive_fault(recursive_fault)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- reference model (behavioural)
   int          m_st;
   int          m_kind;
   logic [7:0]  m_tv, m_fv, m_iv;
   logic [31:0] m_pc, m_ccs, m_sp, m_ksp, m_ebp, m_rd;
   int          m_dsl;
   bit          m_leg, m_fatal, m_rec;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_kind = 0; m_fatal = 0; m_rec = 0; m_leg = 0;
         m_tv = 0; m_fv = 0; m_iv = 0; m_pc = 0; m_ccs = 0; m_sp = 0;
         m_ksp = 0; m_ebp = 0; m_rd = 0; m_dsl = 0;
      end else begin
         m_fatal = (m_st == 0) && req_valid && req_kind == 2 && core_ver < 32;
         m_rec   = (m_st != 0) && req_valid && req_kind == 2 && m_kind == 2;
         if (m_st == 0) begin
            if (req_valid && !(req_kind == 2 && core_ver < 32)) begin
               m_kind = req_kind; m_tv = trap_vec; m_fv = fault_vec; m_iv = irq_vec;
               m_pc = pc_in; m_ccs = ccs_in; m_sp = sp_in; m_ksp = ksp_in;
               m_ebp = ebp_in; m_dsl = dslot_len; m_leg = core_ver < 32;
               m_st = 1;
            end
         end else if (m_st == 1) m_st = 2;
         else if (m_st == 2) begin
            if (mem_rd_valid) begin m_rd = mem_rd_data; m_st = 3; end
         end else m_st = 0;
      end
   end

   // ---------------- compare every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         int          v;
         logic [31:0] ret, c;
         bit          upd;
         upd = (m_st == 1);
         case (m_kind)
            0: v = m_tv;
            1: v = 0;
            2: v = m_fv;
            default: v = m_iv;
         endcase
         ret = (!m_leg && m_dsl != 0) ? m_pc - m_dsl : m_pc;
         c = m_ccs;
         if (m_kind == 1) c = c & ~32'h200;
         if (!m_leg) c = ((c & 32'hC000_0000) | ((c << 12) >> 2)) & ~32'h3FF;

         chk("R11 busy", busy, m_st != 0);
         chk("R1 erp_we", erp_we, upd && m_kind != 1);
         chk("R2 nrp_we", nrp_we, upd && m_kind == 1);
         if (upd && m_kind != 1) chk(m_leg ? "R9 erp_val" : "R3 erp_val", erp_val, ret);
         if (upd && m_kind == 1) chk(m_leg ? "R9 nrp_val" : "R2 nrp_val", nrp_val, ret);
         chk("R11 ccs_we", ccs_we, upd);
         if (upd) chk(m_leg ? "R9 ccs_val" : "R7 ccs_val", ccs_val, c);
         chk(m_leg ? "R9 exs_we" : "R4 exs_we", exs_we, upd && !m_leg);
         if (upd && !m_leg) chk("R4 exs_val", exs_val, (v & 32'hFF) << 8);
         chk("R6 usp_we", usp_we, upd && m_ccs[8]);
         chk("R6 sp_we", sp_we, upd && m_ccs[8]);
         if (upd && m_ccs[8]) begin
            chk("R6 usp_val", usp_val, m_sp);
            chk("R6 sp_val", sp_val, m_ksp);
         end
         chk(m_leg ? "R9 dslot_clr" : "R5 dslot_clr", dslot_clr, upd && !m_leg && m_dsl != 0);
         chk("R8 mem_rd_req", mem_rd_req, m_st == 2);
         if (m_st == 2) chk("R8 mem_rd_addr", mem_rd_addr, m_ebp + v * 4);
         chk("R8 pc_we", pc_we, m_st == 3);
         chk("R8 done", done, m_st == 3);
         if (m_st == 3) chk("R8 pc_val", pc_val, m_rd);
         chk("R10 fatal", fatal_bus_err, m_fatal);
         chk("R12 recursive", recursive_fault, m_rec);
      end
   end

   // ---------------- memory responder
   int lat = 0;
   int wcnt = 0;
   always @(negedge clk) begin
      if (mem_rd_req && !mem_rd_valid) begin
         if (wcnt >= lat) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem_rd_addr ^ 32'h5A5A_0F0F;
         end else wcnt++;
      end else begin
         mem_rd_valid <= 1'b0;
         wcnt = 0;
      end
   end

   // ---------------- stimulus
   task automatic entry(input int kind, input logic [7:0] ver, input logic [31:0] ccs,
                        input int dsl, input int l, input int inj_kind, input bit inj);
      @(negedge clk);
      lat = l;
      req_kind = kind[1:0]; core_ver = ver; ccs_in = ccs; dslot_len = dsl[1:0];
      trap_vec = 8'h11 + kind[7:0]; fault_vec = 8'hC3; irq_vec = 8'h7E;
      pc_in = 32'h0000_4000 + kind * 32'h100; sp_in = 32'hBEEF_0000 + kind;
      ksp_in = 32'hCAFE_0000 + kind; ebp_in = 32'h0010_0000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (inj) begin
         @(negedge clk);
         req_kind = inj_kind[1:0]; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      for (int i = 0; i < 12; i++) @(negedge clk);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog got=%0d exp=<100000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 0; trap_vec = 0; fault_vec = 0;
      irq_vec = 0; pc_in = 0; dslot_len = 0; core_ver = 8'd32; ccs_in = 0;
      sp_in = 0; ksp_in = 0; ebp_in = 0; mem_rd_valid = 1'b0; mem_rd_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // current core
      entry(0, 8'd32, 32'hC00F_F3FF, 0, 0, 0, 0);   // R1 break, user mode R6 R7
      entry(1, 8'd40, 32'h0000_0200, 2, 1, 0, 0);   // R2 nmi, rewind R5
      entry(2, 8'd32, 32'h8001_0100, 1, 2, 0, 0);   // R3 bus fault
      entry(3, 8'd99, 32'h5555_AAAA, 3, 3, 0, 0);   // R3 irq, R4
      entry(3, 8'd32, 32'hFFFF_FFFF, 0, 3, 0, 1);   // R11 break ignored while busy
      entry(2, 8'd32, 32'h0000_0000, 0, 3, 2, 1);   // R12 recursive bus fault
      entry(3, 8'd32, 32'h0000_0000, 0, 3, 2, 1);   // R12 not flagged for irq entry
      // older core
      entry(1, 8'd10, 32'h4000_0301, 3, 0, 0, 0);   // R9 nmi
      entry(3, 8'd31, 32'h1234_5678, 2, 1, 0, 0);   // R9 irq, no rewind
      entry(0, 8'd0,  32'h0000_0100, 1, 2, 0, 0);   // R9 break with swap
      entry(2, 8'd10, 32'h0000_0100, 1, 0, 0, 0);   // R10 fatal, no entry
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule